// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between five external interrupt pins and the interrupt controller. Each pin is brought into the clock domain through a two-stage synchroniser. Three of the sources can pass through an optional digital noise filter and have a selectable active edge. One of those three can also be set to respond to both edges, but only when two separate control registers agree. Every qualifying edge sets a sticky request flag, which stays up until the controller acknowledges that source.

The source numbered 0 shares its pin with a general-purpose port bit. After reset the pin is a port. While it is a port, its synchronised value is still presented on a port output, but it raises no request. Sources 0 and 4 always respond to a falling edge and are never filtered.

Each noise filter is a small state machine with two named states. In HOLD it has an accepted level and the input agrees with it. In WATCH the input differs from that level and a run counter is advancing. The transition HOLD to WATCH happens on the first sample that disagrees. The transition WATCH to HOLD (reject) happens when the input returns to the old level before the run completes. The transition WATCH to HOLD (accept) happens when `FILT_LEN` consecutive samples have disagreed; the accepted level then changes.

Top module: `ext_irq_conditioner`

## Requirements
- R1: After reset all request flags are 0, both control registers read 0, and source 0 is in port mode.
- R2: `port_p10_o` equals the level of `pin_i[0]` as sampled two rising clock edges earlier.
- R3: Sources 0 and 4 set their request on a falling edge of their pin. They never respond to a rising edge, and the filter-enable bits have no effect on them.
- R4: When control A bit 0 is 0 (port mode), a falling edge on `pin_i[0]` leaves `irq_req_o[0]` at 0. When the bit is 1, the edge sets the request.
- R5: For sources 1, 2 and 3, control A bit k (k = source number) selects the active edge: 0 means falling, 1 means rising. An edge of the other polarity sets nothing.
- R6: When the filter of source k (k = 1..3) is enabled by control A bit 3+k, a level is accepted only after the synchronised input has held it for `FILT_LEN` consecutive clocks. Shorter pulses set no request.
- R7: When that filter-enable bit is 0, the source bypasses the filter, and a one-clock pulse produces an edge.
- R8: Source 3 responds to both edges only when control A bit 7 and control B bit 0 are both 1. With only one of them set, the bit 3 edge selection applies.
- R9: A request stays at 1 until the same source's `ack_i` bit is 1 at a clock edge. If a new edge arrives on the same edge as the acknowledge, the request stays at 1.
- R10: Writes with `reg_sel`=0 load all 8 bits of control A. Writes with `reg_sel`=1 load only bit 0 of control B. `reg_rdata_o` returns the selected register, with unimplemented bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 5 | Raw pins; bit 4 is the fifth source |
| ack_i | input | 5 | Per-source request acknowledge |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 1 | 0 selects control A, 1 selects control B |
| reg_wdata | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_req_o | output | 5 | Sticky interrupt request per source |
| port_p10_o | output | 1 | Synchronised port value of the shared pin 0 |

## Verification
The bench builds the block with `FILT_LEN` = 3. With that value, a two-clock glitch is rejected and a three-clock pulse is accepted, so both filter exits are reached within a handful of cycles. Both outputs are compared on every clock against a behavioural model that counts mismatching samples. Directed sequences cover the dual-register both-edge gating, port-mode suppression, and the cycle where an acknowledge coincides with a new edge.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int NUM_SRC  = 5;
    localparam int REG_W    = 8;
    localparam int FLT_SRCS = 3;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_BOTH = 2'd2
    } edge_mode_e;

    typedef enum logic {
        FLT_HOLD  = 1'b0,
        FLT_WATCH = 1'b1
    } flt_state_e;

    typedef struct packed {
        logic                dual_arm;
        logic [FLT_SRCS-1:0] flt_en;
        logic [FLT_SRCS-1:0] edge_rise;
        logic                irq_fn;
    } ctrl_a_t;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            stage2_q <= RST_VAL;
        end else begin
            stage1_q <= d_i;
            stage2_q <= stage1_q;
        end
    end

    assign q_o = stage2_q;
endmodule

// File: rtl/eic_noise_filter.sv
module eic_noise_filter
    import eic_pkg::*;
#(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    output logic lvl_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FILT_LEN - 1);

    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             lvl_q, lvl_d;

    initial begin
        if (FILT_LEN < 2) $error("FILT_LEN must be at least 2");
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLT_HOLD;
            cnt_q   <= '0;
            lvl_q   <= RST_VAL;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        unique case (state_q)
            FLT_HOLD: begin
                if (din_i != lvl_q) begin
                    state_d = FLT_WATCH;
                    cnt_d   = CNT_W'(1);
                end
            end
            FLT_WATCH: begin
                if (din_i == lvl_q) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = FLT_HOLD;
                    cnt_d   = '0;
                    lvl_d   = din_i;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_d = FLT_HOLD;
                cnt_d   = '0;
            end
        endcase
    end

    assign lvl_o = lvl_q;

    assert_level_from_watch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> ($past(state_q) == FLT_WATCH && $past(din_i) == lvl_q));

    assert_run_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q < CNT_W'(FILT_LEN)));

    assert_hold_counter_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLT_HOLD) |-> (cnt_q == '0));
endmodule

// File: rtl/eic_edge_latch.sv
module eic_edge_latch
    import eic_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  edge_mode_e mode_i,
    input  logic       arm_i,
    input  logic       ack_i,
    output logic       req_o
);
    logic prev_q;
    logic req_q;
    logic rise, fall, hit;

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;

    always_comb begin
        hit = 1'b0;
        unique case (mode_i)
            EDGE_FALL: hit = fall;
            EDGE_RISE: hit = rise;
            EDGE_BOTH: hit = rise | fall;
            default:   hit = 1'b0;
        endcase
        hit = hit & arm_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= RST_VAL;
            req_q  <= 1'b0;
        end else begin
            prev_q <= lvl_i;
            req_q  <= hit | (req_q & ~ack_i);
        end
    end

    assign req_o = req_q;

    assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_q && !ack_i) |=> req_q);

    assert_req_rise_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> $past(arm_i));

    assert_req_rise_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_q) |-> ($past(lvl_i) != $past(prev_q)));
endmodule

// File: rtl/ext_irq_conditioner.sv
module ext_irq_conditioner
    import eic_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pin_i,
    input  logic [NUM_SRC-1:0] ack_i,
    input  logic               reg_we,
    input  logic               reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic [NUM_SRC-1:0] irq_req_o,
    output logic               port_p10_o
);
    localparam logic IDLE_LVL = 1'b1;
    localparam int   DUAL_SRC = 3;

    ctrl_a_t ctrl_a_q;
    logic    dual_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_a_q  <= '0;
            dual_ok_q <= 1'b0;
        end else if (reg_we) begin
            if (reg_sel) dual_ok_q <= reg_wdata[0];
            else         ctrl_a_q  <= ctrl_a_t'(reg_wdata);
        end
    end

    assign reg_rdata_o = reg_sel ? {{(REG_W-1){1'b0}}, dual_ok_q} : REG_W'(ctrl_a_q);

    logic [NUM_SRC-1:0] sync_lvl;
    logic [NUM_SRC-1:0] sel_lvl;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_src
        edge_mode_e mode;
        logic       arm;

        eic_sync #(.RST_VAL(IDLE_LVL)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (pin_i[k]),
            .q_o   (sync_lvl[k])
        );

        if (k >= 1 && k <= FLT_SRCS) begin : g_filtered
            logic flt_lvl;
            eic_noise_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(IDLE_LVL)) u_flt (
                .clk   (clk),
                .rst_n (rst_n),
                .din_i (sync_lvl[k]),
                .lvl_o (flt_lvl)
            );
            assign sel_lvl[k] = ctrl_a_q.flt_en[k-1] ? flt_lvl : sync_lvl[k];
            if (k == DUAL_SRC) begin : g_dual
                assign mode = (ctrl_a_q.dual_arm && dual_ok_q) ? EDGE_BOTH :
                              (ctrl_a_q.edge_rise[k-1] ? EDGE_RISE : EDGE_FALL);
            end else begin : g_single
                assign mode = ctrl_a_q.edge_rise[k-1] ? EDGE_RISE : EDGE_FALL;
            end
            assign arm = 1'b1;
        end else begin : g_plain
            assign sel_lvl[k] = sync_lvl[k];
            assign mode       = EDGE_FALL;
            if (k == 0) begin : g_shared
                assign arm = ctrl_a_q.irq_fn;
            end else begin : g_dedicated
                assign arm = 1'b1;
            end
        end

        eic_edge_latch #(.RST_VAL(IDLE_LVL)) u_latch (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (sel_lvl[k]),
            .mode_i (mode),
            .arm_i  (arm),
            .ack_i  (ack_i[k]),
            .req_o  (irq_req_o[k])
        );
    end

    assign port_p10_o = sync_lvl[0];

    assert_port_mode_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o[0]) |-> $past(ctrl_a_q.irq_fn));

    assert_port_two_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (port_p10_o != $past(port_p10_o)) |-> (port_p10_o == $past(pin_i[0], 2)));

    assert_fixed_fall_src4_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req_o[4]) |-> ($past(sel_lvl[4]) == 1'b0));

    assert_single_edge_src3_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_req_o[3]) && !$past(ctrl_a_q.dual_arm && dual_ok_q))
            |-> ($past(sel_lvl[3]) == $past(ctrl_a_q.edge_rise[2])));

    assert_ctrl_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> ($stable(ctrl_a_q) && $stable(dual_ok_q)));
endmodule

// File: tb/ext_irq_conditioner_tb_top.sv
module ext_irq_conditioner_tb_top;
    localparam int N  = 3;
    localparam int NS = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] pin_i = '1;
    logic [NS-1:0] ack_i = '0;
    logic          reg_we = 1'b0;
    logic          reg_sel = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata_o;
    logic [NS-1:0] irq_req_o;
    logic          port_p10_o;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ext_irq_conditioner #(.FILT_LEN(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .ack_i(ack_i),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata_o(reg_rdata_o), .irq_req_o(irq_req_o), .port_p10_o(port_p10_o)
    );

    // behavioural reference model
    bit   m_s1[NS], m_s2[NS], m_lvl[NS], m_prev[NS], m_req[NS];
    int   m_run[NS];
    logic [7:0] m_a;
    bit   m_b;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NS; k++) begin
                m_s1[k] = 1; m_s2[k] = 1; m_lvl[k] = 1; m_prev[k] = 1;
                m_req[k] = 0; m_run[k] = 0;
            end
            m_a = 8'h00; m_b = 0;
        end else begin
            for (int k = 0; k < NS; k++) begin
                bit fen, sel, rise, fall, hit;
                fen  = (k >= 1 && k <= 3) ? m_a[3+k] : 1'b0;
                sel  = fen ? m_lvl[k] : m_s2[k];
                rise = sel && !m_prev[k];
                fall = !sel && m_prev[k];
                if (k == 0)      hit = fall && m_a[0];
                else if (k == 4) hit = fall;
                else if (k == 3 && m_a[7] && m_b) hit = rise || fall;
                else             hit = m_a[k] ? rise : fall;
                m_req[k]  = hit || (m_req[k] && !ack_i[k]);
                m_prev[k] = sel;
                if (m_s2[k] != m_lvl[k]) begin
                    m_run[k]++;
                    if (m_run[k] == N) begin m_lvl[k] = m_s2[k]; m_run[k] = 0; end
                end else m_run[k] = 0;
                m_s2[k] = m_s1[k];
                m_s1[k] = pin_i[k];
            end
            if (reg_we) begin
                if (reg_sel) m_b = reg_wdata[0];
                else         m_a = reg_wdata;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        tests_run++;
        if (act != exp) begin
            tests_failed++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int k = 0; k < NS; k++)
                check($sformatf("R9 model irq[%0d] (R3 R4 R5 R6 R7 R8)", k), irq_req_o[k], m_req[k]);
            check("R2 model port", port_p10_o, m_s2[0]);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        tick(1);
        reg_we = 0; reg_sel = 0;
    endtask

    task automatic ack(input logic [NS-1:0] m);
        ack_i = m;
        tick(1);
        ack_i = '0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests_failed++;
        $display("FAIL watchdog actual=expired expected=complete");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1 reset state
        check("R1 irq after reset", irq_req_o, 0);
        reg_sel = 0; #1 check("R1 ctrl A reset", reg_rdata_o, 0);
        reg_sel = 1; #1 check("R1 ctrl B reset", reg_rdata_o, 0);
        reg_sel = 0;
        check("R1 port idle", port_p10_o, 1);
        tick(1);
        // R10 register access
        wr(0, 8'hFF); #1 check("R10 ctrl A readback", reg_rdata_o, 8'hFF);
        tick(1);
        wr(1, 8'hFF); reg_sel = 1; #1 check("R10 ctrl B only bit0", reg_rdata_o, 8'h01);
        reg_sel = 0;
        tick(1);
        wr(0, 8'h00); wr(1, 8'h00);
        // R2 synchroniser latency
        pin_i[0] = 0;
        tick(1); check("R2 port after one edge", port_p10_o, 1);
        tick(1); check("R2 port after two edges", port_p10_o, 0);
        // R4 port mode suppresses
        tick(4); check("R4 port mode no request", irq_req_o[0], 0);
        pin_i[0] = 1; tick(4);
        // R3 fixed falling, unfiltered, filter bits set
        wr(0, 8'h71);
        pin_i[0] = 0; tick(1); pin_i[0] = 1; tick(5);
        check("R4 interrupt mode request", irq_req_o[0], 1);
        pin_i[4] = 0; tick(1); pin_i[4] = 1; tick(5);
        check("R3 src4 short pulse unfiltered", irq_req_o[4], 1);
        ack(5'b10001);
        check("R9 ack clears 0 and 4", irq_req_o & 5'b10001, 0);
        // R5 edge select
        wr(0, 8'h03);
        pin_i[1] = 0; tick(5); check("R5 src1 falling ignored", irq_req_o[1], 0);
        pin_i[1] = 1; tick(5); check("R5 src1 rising taken", irq_req_o[1], 1);
        ack(5'b00010);
        pin_i[2] = 0; tick(5); check("R5 src2 falling taken", irq_req_o[2], 1);
        ack(5'b00100);
        pin_i[2] = 1; tick(5); check("R5 src2 rising ignored", irq_req_o[2], 0);
        // R6 filter
        wr(0, 8'h13);
        pin_i[1] = 0; tick(8); check("R6 filtered fall ignored", irq_req_o[1], 0);
        pin_i[1] = 1; tick(2); pin_i[1] = 0; tick(8);
        check("R6 two-clock glitch rejected", irq_req_o[1], 0);
        pin_i[1] = 1; tick(3); pin_i[1] = 0; tick(8);
        check("R6 three-clock pulse accepted", irq_req_o[1], 1);
        ack(5'b00010);
        // R7 bypass
        wr(0, 8'h03);
        pin_i[1] = 1; tick(1); pin_i[1] = 0; tick(6);
        check("R7 bypass one-clock pulse", irq_req_o[1], 1);
        ack(5'b00010);
        pin_i[1] = 1; tick(6); ack(5'b00010);
        // R8 dual-edge gating
        wr(0, 8'h01); wr(1, 8'h01);
        pin_i[3] = 0; tick(6); check("R8 B alone falling", irq_req_o[3], 1);
        ack(5'b01000);
        pin_i[3] = 1; tick(6); check("R8 B alone no rising", irq_req_o[3], 0);
        wr(0, 8'h81); wr(1, 8'h00);
        pin_i[3] = 0; tick(6); ack(5'b01000);
        pin_i[3] = 1; tick(6); check("R8 A alone no rising", irq_req_o[3], 0);
        wr(1, 8'h01);
        pin_i[3] = 0; tick(6); check("R8 both set falling", irq_req_o[3], 1);
        ack(5'b01000);
        pin_i[3] = 1; tick(6); check("R8 both set rising", irq_req_o[3], 1);
        ack(5'b01000);
        // R9 sticky and set-over-ack
        pin_i[4] = 0; tick(6);
        tick(20); check("R9 request held", irq_req_o[4], 1);
        pin_i[4] = 1; tick(4);
        pin_i[4] = 0; tick(2);
        ack_i = 5'b10000; tick(1); ack_i = '0;
        check("R9 edge wins over ack", irq_req_o[4], 1);
        ack(5'b10000);
        check("R9 ack clears", irq_req_o[4], 0);
        pin_i[4] = 1; tick(4);
        finish_run();
    end
endmodule